// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block is a small timer in which a single up-counter, clocked through a power-of-two prescaler, sets the period for several edge-aligned PWM channels. Software sets it up over a simple memory-mapped read/write port. There is a control register for the prescale exponent and the clock mode, a counter register, a period (modulo) register, and one control/compare register pair for each channel. Each channel drives one output pin.

All channels share one period. The counter runs from 0 up to the modulo value, inclusive, and then returns to 0. That return marks the start of a new period. While the counter is running, writes to the modulo and compare registers go into holding copies. The holding copies move into the active registers at the next period start. While the counter is stopped, the same writes reach the active registers at once. A readback always returns the active value, so software can poll until its write has taken effect.

The polarity/enable field of each channel is different: a change to it reaches the pin at once, without waiting for a period boundary. Each channel also raises a flag when the counter passes its compare value. Software clears the flag by writing 1 to it.

Top module: `shared_ctr_pwm`

## Requirements
- R1: After reset the counter reads 0, the modulo reads 0xFFFF, the control register reads 0, every compare value and channel control reads 0, and every output is low. Address 0x04 reads the channel count.
- R2: The control register holds the prescale exponent in bits [2:0]. While the counter runs, it advances by one every 2^exponent clock cycles. After the run starts, the first advance occurs 2^exponent cycles after the control write.
- R3: When running, the counter steps from 0 up to the active modulo value and then returns to 0 on the next advance. Any write to the counter register (address 0x14) clears the counter to 0.
- R4: When the clock mode is 2'b00, a write to the modulo register (0x18) or to a compare register (0x24 + 8·n) reads back the new value in the next cycle.
- R5: When the clock mode is nonzero, modulo and compare writes go into holding copies. The readback keeps its previous value until the counter returns to 0, and from that point it shows the new value.
- R6: Channel control bits [3:2] select the output level. With code 2'b10 (normal), the output is high while counter < compare and low otherwise. A compare value of 0 therefore gives a constantly low output, and a compare value above the modulo gives a constantly high output.
- R7: Level code 2'b01 gives the complement of the normal waveform. Reserved code 2'b11 behaves the same as normal.
- R8: Level code 2'b00 drives the output low. A change to the level field reaches the output in the cycle after the write, without waiting for a period boundary.
- R9: Channel control bit 7 is set when the counter advances away from a value equal to that channel's compare value. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged.
- R10: With clock mode 2'b00 (control bits [4:3]) the counter holds its value.
- R11: Control bits [2:0], [4:3] and bit 5 read back as written. Bit 5 has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The hardest case to reach is a modulo or compare write made while the counter runs, observed before and after the period boundary that loads it. If the write lands on the same edge as the boundary, the value waits a whole extra period. To avoid this, the bench first clears the counter through its register so the boundary is a known number of cycles away. It then writes the new values and reads back the old ones. Next it polls the counter until the counter returns to 0, and confirms both the new values and the shorter period. The flag test uses a similar approach: it clears the counter while the timer is stopped, so the cycle in which the flag rises is exact.

// File: rtl/shared_ctr_pwm.sv
module shared_ctr_pwm #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PSW = 3,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int DIVW = 1 << PSW;
  localparam logic [AW-1:0] A_INFO = AW'(8'h04);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h10);
  localparam logic [AW-1:0] A_CNT  = AW'(8'h14);
  localparam logic [AW-1:0] A_MOD  = AW'(8'h18);

  function automatic logic [AW-1:0] ctl_addr(int i);
    return AW'(32'h20 + 8 * i);
  endfunction
  function automatic logic [AW-1:0] cmp_addr(int i);
    return AW'(32'h24 + 8 * i);
  endfunction

  logic [PSW-1:0]   ps_q;
  logic [1:0]       mode_q;
  logic             center_q;
  logic [DIVW-1:0]  div_q;
  logic [CW-1:0]    cnt_q, mod_act, mod_buf;
  logic [CW-1:0]    cmp_act [NCH];
  logic [CW-1:0]    cmp_buf [NCH];
  logic [1:0]       lvl_q   [NCH];
  logic [1:0]       msel_q  [NCH];
  logic [NCH-1:0]   flag_q;
  logic [2*NCH-1:0] lvl_vec;

  wire unused_wdata = ^bus_wdata[DW-1:CW];

  wire             run     = |mode_q;
  wire [DIVW-1:0]  div_lim = (DIVW'(1) << ps_q) - DIVW'(1);
  wire             tick    = run && (div_q == div_lim);
  wire             wrap    = tick && (cnt_q >= mod_act);
  wire             wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire             wr_cnt  = bus_wr && (bus_addr == A_CNT);
  wire             wr_mod  = bus_wr && (bus_addr == A_MOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q     <= '0;
      mode_q   <= '0;
      center_q <= 1'b0;
    end else if (wr_ctrl) begin
      ps_q     <= bus_wdata[PSW-1:0];
      mode_q   <= bus_wdata[4:3];
      center_q <= bus_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (!run || wr_cnt)   div_q <= '0;
    else if (tick)             div_q <= '0;
    else                       div_q <= div_q + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= '0;
    else if (tick)   cnt_q <= (cnt_q >= mod_act) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_act <= '1;
      mod_buf <= '1;
    end else begin
      if (wr_mod) begin
        mod_buf <= bus_wdata[CW-1:0];
        if (!run) mod_act <= bus_wdata[CW-1:0];
      end
      if (wrap) mod_act <= mod_buf;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire wr_cctl = bus_wr && (bus_addr == ctl_addr(i));
    wire wr_ccmp = bus_wr && (bus_addr == cmp_addr(i));
    wire hi      = cnt_q < cmp_act[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_act[i] <= '0;
        cmp_buf[i] <= '0;
      end else begin
        if (wr_ccmp) begin
          cmp_buf[i] <= bus_wdata[CW-1:0];
          if (!run) cmp_act[i] <= bus_wdata[CW-1:0];
        end
        if (wrap) cmp_act[i] <= cmp_buf[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[i]  <= '0;
        msel_q[i] <= '0;
        flag_q[i] <= 1'b0;
      end else begin
        if (wr_cctl) begin
          lvl_q[i]  <= bus_wdata[3:2];
          msel_q[i] <= bus_wdata[5:4];
        end
        if (tick && (cnt_q == cmp_act[i])) flag_q[i] <= 1'b1;
        else if (wr_cctl && bus_wdata[7])  flag_q[i] <= 1'b0;
      end
    end

    assign lvl_vec[2*i +: 2] = lvl_q[i];
    assign pwm_out[i] = (lvl_q[i] == 2'b00) ? 1'b0 :
                        (lvl_q[i] == 2'b01) ? ~hi : hi;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_INFO:  bus_rdata = DW'(NCH);
      A_CTRL:  bus_rdata = DW'({center_q, mode_q, ps_q});
      A_CNT:   bus_rdata = DW'(cnt_q);
      A_MOD:   bus_rdata = DW'(mod_act);
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ctl_addr(i))
        bus_rdata = DW'({flag_q[i], 1'b0, msel_q[i], lvl_q[i], 2'b00});
      if (bus_addr == cmp_addr(i))
        bus_rdata = DW'(cmp_act[i]);
    end
  end
endmodule

module shared_ctr_pwm_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic           tick,
  input logic           cnt_clr,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  mod,
  input logic [2*NCH-1:0] lvl,
  input logic [NCH-1:0] out
);
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clr && cnt >= mod) |=> (cnt == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clr && cnt < mod) |=> (cnt == $past(cnt) + CW'(1)));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_clr) |=> $stable(cnt));

  a_r5_mod_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && cnt >= mod)) |=> $stable(mod));

  for (genvar i = 0; i < NCH; i++) begin : g_off
    a_r8_off: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[2*i +: 2] == 2'b00) |-> !out[i]);
  end
endmodule

bind shared_ctr_pwm shared_ctr_pwm_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt_clr(wr_cnt),
  .cnt(cnt_q), .mod(mod_act), .lvl(lvl_vec), .out(pwm_out)
);

// File: tb/shared_ctr_pwm_bench.sv
`timescale 1ns/1ps
module shared_ctr_pwm_bench;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  pwm_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_ctr_pwm u_shared_ctr_pwm (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h14, d); chk("R1 counter", d, 0);
    rd(8'h18, d); chk("R1 modulo", d, 32'hFFFF);
    rd(8'h10, d); chk("R1 control", d, 0);
    rd(8'h04, d); chk("R1 channel count", d, 4);
    for (int i = 0; i < 4; i++) begin
      rd(8'h20 + 8'(8 * i), d); chk("R1 channel control", d, 0);
      rd(8'h24 + 8'(8 * i), d); chk("R1 compare", d, 0);
    end
    chk("R1 outputs", 32'(pwm_out), 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h10, 32'h25); rd(8'h10, d); chk("R11 control readback", d, 32'h25);
    rd(8'h14, d); chk("R11 center bit does not run counter", d, 0);
    wr(8'h10, 0);
  endtask

  task automatic t_stopped();
    logic [31:0] d;
    wr(8'h18, 9); rd(8'h18, d); chk("R4 modulo immediate", d, 9);
    wr(8'h24, 4); rd(8'h24, d); chk("R4 compare immediate", d, 4);
  endtask

  task automatic t_count();
    logic [31:0] d, held;
    wr(8'h14, 0); wr(8'h10, 32'h08);
    wait_n(5); rd(8'h14, d); chk("R3 count up", d, 5);
    wait_n(4); rd(8'h14, d); chk("R3 reaches modulo", d, 9);
    wait_n(1); rd(8'h14, d); chk("R3 wrap to zero", d, 0);
    wait_n(3); rd(8'h14, d); chk("R3 after wrap", d, 3);
    wr(8'h14, 32'h55); rd(8'h14, d); chk("R3 counter write clears", d, 0);
    wr(8'h10, 0); rd(8'h14, held);
    wait_n(5); rd(8'h14, d); chk("R10 stopped counter holds", d, held);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    wr(8'h14, 0); wr(8'h10, 32'h0A);
    wait_n(3); rd(8'h14, d); chk("R2 no advance before 4 clocks", d, 0);
    wait_n(1); rd(8'h14, d); chk("R2 first advance", d, 1);
    wait_n(4); rd(8'h14, d); chk("R2 second advance", d, 2);
    wr(8'h10, 0);
  endtask

  task automatic t_pwm();
    logic [31:0] d;
    logic [3:0] e;
    wr(8'h24, 4); wr(8'h2C, 4); wr(8'h34, 0); wr(8'h3C, 15);
    wr(8'h20, 32'h28); wr(8'h28, 32'h24); wr(8'h30, 32'h2C); wr(8'h38, 32'h28);
    wr(8'h14, 0); wr(8'h10, 32'h08);
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      rd(8'h14, d);
      e[0] = d < 4; e[1] = !(d < 4); e[2] = 1'b0; e[3] = 1'b1;
      chk("R6 R7 waveform", 32'(pwm_out), 32'(e));
    end
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h20, 32'h20);
    for (int k = 0; k < 10; k++) begin
      chk("R8 disabled output low", 32'(pwm_out[0]), 0);
      @(negedge clk);
    end
    wr(8'h28, 32'h28); rd(8'h14, d);
    chk("R8 polarity change immediate", 32'(pwm_out[1]), 32'(d < 4));
    wr(8'h20, 32'h28); rd(8'h14, d);
    chk("R8 re-enable immediate", 32'(pwm_out[0]), 32'(d < 4));
  endtask

  task automatic t_buffered();
    logic [31:0] d;
    wr(8'h14, 0);
    wr(8'h18, 5); rd(8'h18, d); chk("R5 modulo held while running", d, 9);
    wr(8'h24, 2); rd(8'h24, d); chk("R5 compare held while running", d, 4);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); rd(8'h14, d);
      if (d == 0) break;
    end
    chk("R5 reached period start", d, 0);
    rd(8'h18, d); chk("R5 modulo loaded at period start", d, 5);
    rd(8'h24, d); chk("R5 compare loaded at period start", d, 2);
    wait_n(5); rd(8'h14, d); chk("R5 new period top", d, 5);
    wait_n(1); rd(8'h14, d); chk("R5 new period wrap", d, 0);
  endtask

  task automatic t_flag();
    logic [31:0] d;
    wr(8'h10, 0); wr(8'h18, 9); wr(8'h24, 3); wr(8'h14, 0);
    wr(8'h20, 32'hA8); rd(8'h20, d); chk("R9 flag cleared", d, 32'h28);
    wr(8'h10, 32'h08);
    wait_n(3); rd(8'h20, d); chk("R9 flag not yet set", d[7], 0);
    wait_n(1); rd(8'h20, d); chk("R9 flag set on match", d[7], 1);
    wr(8'h10, 0);
    wr(8'h20, 32'h28); rd(8'h20, d); chk("R9 writing 0 keeps flag", d[7], 1);
    wr(8'h20, 32'hA8); rd(8'h20, d); chk("R9 writing 1 clears flag", d[7], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_stopped();
    t_count();
    t_prescale();
    t_pwm();
    t_level();
    t_buffered();
    t_flag();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule